// File: doc/BRIEF.md
# Buffered Timer Time Base

This block is the counting core of a general-purpose timer. A 16-bit counter advances on ticks from a programmable clock divider. The counter can run upward, downward, or swing back and forth between the two directions. Each time it reaches a limit it emits a one-clock update pulse. The limit comes from an auto-reload value. Software writes that value into a buffer register, and the counter compares against a separate shadow copy of it.

A small register port lets software read and write the control word, the counter, the divider setting and the auto-reload buffer at any time, including while the counter runs. A control bit chooses how the shadow copy follows the buffer: it either tracks the buffer continuously, or takes the buffer's value only at update events. The divider setting is always held in a preload register and only takes effect at the next update event. This lets software retime the counter without glitches.

Top module: `timer_timebase`

## Requirements
- R1: After reset the counter, the divider setting and the control word read 0, the auto-reload buffer reads 0xFFFF, and upd_o and dir_o are 0.
- R2: Register addresses are 0 for control, 1 for counter, 2 for divider and 3 for auto-reload. The control word holds bit 0 = enable, bits 2:1 = mode (00 up, 01 down, 10 alternating, 11 behaves as up) and bit 3 = reload-at-update. Reads return the last written value, and reading address 3 returns the buffer, not the shadow.
- R3: In up mode, each tick increments the counter. A tick at or above the shadow limit wraps the counter to 0 and pulses upd_o for one clock together with the new value.
- R4: In down mode, each tick decrements the counter. A tick at 0 loads the shadow limit and pulses upd_o.
- R5: In alternating mode, the counter rises until it reaches limit-1 and then falls until it reaches 1. Each turnaround steps one count in the new direction and pulses upd_o.
- R6: Ticks occur once every PSC+1 clocks. A newly written divider value takes effect only at the next update event.
- R7: While the enable bit is 0, the counter holds its value, no update pulse occurs, and the divider's phase counter is held cleared.
- R8: With reload-at-update = 0, the shadow limit follows the buffer one clock after a write. With reload-at-update = 1, the shadow limit changes only at update events.
- R9: A counter write takes effect in the next clock. It overrides that clock's count step and produces no update pulse.
- R10: dir_o is 0 in up mode and 1 in down mode. In alternating mode it is 1 during the falling phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| cnt_o | output | 16 | Counter value |
| dir_o | output | 1 | Count direction, 1 = downward |
| upd_o | output | 1 | Update event pulse |

## Verification
On every cycle the assertions check four things. The counter lands on 0 at an up-mode update and on the previous shadow limit at a down-mode update. A disabled counter neither moves nor pulses. The shadow limit and the active divider setting change only at update events when buffering applies. Only the bench's scenarios can show the following: the exact counting sequences in each mode, including the alternating turnarounds and direction flag; the delayed effect of a new divider setting on tick spacing; a counter write landing in the middle of a run; and read-back of the buffer rather than the shadow.

// File: rtl/timebase_pkg.sv
package timebase_pkg;
  typedef enum logic [1:0] {
    MODE_UP     = 2'd0,
    MODE_DOWN   = 2'd1,
    MODE_CENTER = 2'd2,
    MODE_RSVD   = 2'd3
  } cnt_mode_e;

  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_CNT  = 2'd1;
  localparam logic [ADDR_W-1:0] A_PSC  = 2'd2;
  localparam logic [ADDR_W-1:0] A_ARR  = 2'd3;
endpackage

// File: rtl/tbase_regs.sv
module tbase_regs
  import timebase_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PSC_W  = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              en_o,
  output cnt_mode_e         mode_o,
  output logic              arr_pb_o,
  output logic [PSC_W-1:0]  psc_pre_o,
  output logic [CNT_W-1:0]  arr_buf_o,
  output logic              wr_cnt_o,
  output logic [DATA_W-1:0] rdata_o
);
  assign wr_cnt_o = wr_en_i && (addr_i == A_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o      <= 1'b0;
      mode_o    <= MODE_UP;
      arr_pb_o  <= 1'b0;
      psc_pre_o <= '0;
      arr_buf_o <= '1;
    end else if (wr_en_i) begin
      case (addr_i)
        A_CTRL: begin
          en_o     <= wdata_i[0];
          mode_o   <= cnt_mode_e'(wdata_i[2:1]);
          arr_pb_o <= wdata_i[3];
        end
        A_PSC:   psc_pre_o <= wdata_i[PSC_W-1:0];
        A_ARR:   arr_buf_o <= wdata_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o[3:0] = {arr_pb_o, mode_o, en_o};
      A_CNT:   rdata_o[CNT_W-1:0] = cnt_i;
      A_PSC:   rdata_o[PSC_W-1:0] = psc_pre_o;
      default: rdata_o[CNT_W-1:0] = arr_buf_o;
    endcase
  end
endmodule

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             evt_i,
  input  logic [PSC_W-1:0] psc_pre_i,
  output logic [PSC_W-1:0] psc_act_o,
  output logic             tick_o
);
  logic [PSC_W-1:0] div_q;

  assign tick_o = en_i && (div_q >= psc_act_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q     <= '0;
      psc_act_o <= '0;
    end else begin
      if (!en_i || tick_o) div_q <= '0;
      else                 div_q <= div_q + 1'b1;
      // new ratio only at an update event
      if (evt_i) psc_act_o <= psc_pre_i;
    end
  end
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter
  import timebase_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  cnt_mode_e        mode_i,
  input  logic             arr_pb_i,
  input  logic [CNT_W-1:0] arr_buf_i,
  input  logic             wr_cnt_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] arr_sh_o,
  output logic             dir_o,
  output logic             evt_o,
  output logic             upd_o
);
  logic             dn_q, dn_d;
  logic [CNT_W-1:0] cnt_d, arr_m1;

  assign arr_m1 = (arr_sh_o == '0) ? '0 : arr_sh_o - 1'b1;

  always_comb begin
    cnt_d = cnt_o;
    dn_d  = dn_q;
    evt_o = 1'b0;
    if (tick_i) begin
      case (mode_i)
        MODE_DOWN: begin
          if (cnt_o == '0) begin
            cnt_d = arr_sh_o;
            evt_o = 1'b1;
          end else cnt_d = cnt_o - 1'b1;
        end
        MODE_CENTER: begin
          if (!dn_q) begin
            if (cnt_o >= arr_m1) begin
              evt_o = 1'b1;
              dn_d  = 1'b1;
              cnt_d = (cnt_o == '0) ? '0 : cnt_o - 1'b1;
            end else cnt_d = cnt_o + 1'b1;
          end else begin
            if (cnt_o <= CNT_W'(1)) begin
              evt_o = 1'b1;
              dn_d  = 1'b0;
              cnt_d = cnt_o + 1'b1;
            end else cnt_d = cnt_o - 1'b1;
          end
        end
        default: begin
          if (cnt_o >= arr_sh_o) begin
            cnt_d = '0;
            evt_o = 1'b1;
          end else cnt_d = cnt_o + 1'b1;
        end
      endcase
    end
    // software write wins over the count step
    if (wr_cnt_i) begin
      cnt_d = wdata_i;
      evt_o = 1'b0;
    end
    if (mode_i != MODE_CENTER) dn_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o    <= '0;
      dn_q     <= 1'b0;
      upd_o    <= 1'b0;
      arr_sh_o <= '1;
    end else begin
      cnt_o <= cnt_d;
      dn_q  <= dn_d;
      upd_o <= evt_o;
      if (!arr_pb_i || evt_o) arr_sh_o <= arr_buf_i;
    end
  end

  assign dir_o = (mode_i == MODE_DOWN) || ((mode_i == MODE_CENTER) && dn_q);
endmodule

// File: rtl/timer_timebase.sv
module timer_timebase
  import timebase_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PSC_W  = 16,
  localparam int unsigned DATA_W = (CNT_W > PSC_W) ? CNT_W : PSC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              dir_o,
  output logic              upd_o
);
  logic             en, arr_pb, wr_cnt, tick, evt;
  cnt_mode_e        mode;
  logic [PSC_W-1:0] psc_pre, psc_act;
  logic [CNT_W-1:0] arr_buf, arr_sh;

  tbase_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .cnt_i(cnt_o), .en_o(en), .mode_o(mode), .arr_pb_o(arr_pb),
    .psc_pre_o(psc_pre), .arr_buf_o(arr_buf), .wr_cnt_o(wr_cnt), .rdata_o
  );

  tbase_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i, .rst_ni, .en_i(en), .evt_i(evt), .psc_pre_i(psc_pre),
    .psc_act_o(psc_act), .tick_o(tick)
  );

  tbase_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .mode_i(mode), .arr_pb_i(arr_pb),
    .arr_buf_i(arr_buf), .wr_cnt_i(wr_cnt), .wdata_i(wdata_i[CNT_W-1:0]),
    .cnt_o, .arr_sh_o(arr_sh), .dir_o, .evt_o(evt), .upd_o
  );
endmodule

// File: rtl/timer_timebase_chk.sv
module timer_timebase_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             en_i,
  input logic             wr_cnt_i,
  input logic             arr_pb_i,
  input logic [CNT_W-1:0] arr_sh_i,
  input logic [PSC_W-1:0] psc_act_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             upd_i
);
  a_r3_up_wraps_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && $past(mode_i) == 2'd0) |-> cnt_i == '0);

  a_r4_down_reloads_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && $past(mode_i) == 2'd1) |-> cnt_i == $past(arr_sh_i));

  a_r7_disabled_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(en_i) && !$past(wr_cnt_i)) |-> ($stable(cnt_i) && !upd_i));

  a_r8_shadow_only_at_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(arr_pb_i) && !upd_i) |-> $stable(arr_sh_i));

  a_r6_ratio_only_at_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |-> $stable(psc_act_i));
endmodule

bind timer_timebase timer_timebase_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode), .en_i(en), .wr_cnt_i(wr_cnt),
  .arr_pb_i(arr_pb), .arr_sh_i(arr_sh), .psc_act_i(psc_act), .cnt_i(cnt_o),
  .upd_i(upd_o)
);

// File: tb/timer_timebase_bench.sv
module timer_timebase_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0, rdata, cnt;
  logic        dir, upd;

  typedef struct {
    logic [15:0] c;
    logic        u;
    logic        d;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  always #(CLK_P/2) clk = ~clk;

  timer_timebase u_timer_timebase (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cnt_o(cnt), .dir_o(dir), .upd_o(upd)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // monitor: compare state a quarter period after each edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(cnt == e.c && upd == e.u && dir == e.d, e.tag,
            {cnt[13:0], upd, dir}, {e.c[13:0], e.u, e.d});
      end
    end
  end

  // driver helpers, called at a falling edge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] expv, input string tag);
    addr = a;
    #1;
    chk(rdata == expv, tag, rdata, expv);
  endtask

  task automatic step(input logic [15:0] c, input logic u, input logic d,
                      input string tag);
    exp_t e;
    e.c = c; e.u = u; e.d = d; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cnt == 0 && upd == 0 && dir == 0, "R1 outputs", {cnt[13:0], upd, dir}, 16'h0);
    rd(2'd0, 16'h0000, "R1 ctrl");
    rd(2'd2, 16'h0000, "R1 psc");
    rd(2'd3, 16'hFFFF, "R1 arr");

    // R3 up mode, limit 3
    wr(2'd3, 16'd3);
    wr(2'd1, 16'd0);
    rd(2'd3, 16'd3, "R2 arr readback");
    wr(2'd0, 16'h0001);
    rd(2'd0, 16'h0001, "R2 ctrl readback");
    step(1, 0, 0, "R3 up"); step(2, 0, 0, "R3 up"); step(3, 0, 0, "R3 up");
    step(0, 1, 0, "R3 wrap"); step(1, 0, 0, "R3 up"); step(2, 0, 0, "R3 up");
    step(3, 0, 0, "R3 up"); step(0, 1, 0, "R3 wrap");

    // R4/R10 down mode
    wr(2'd0, 16'h0002);
    wr(2'd1, 16'd3);
    wr(2'd0, 16'h0003);
    step(2, 0, 1, "R4 down"); step(1, 0, 1, "R4 down"); step(0, 0, 1, "R4 down");
    step(3, 1, 1, "R4 reload"); step(2, 0, 1, "R10 dir down");

    // R5 alternating, limit 4
    wr(2'd0, 16'h0004);
    wr(2'd3, 16'd4);
    wr(2'd1, 16'd0);
    wr(2'd0, 16'h0005);
    step(1, 0, 0, "R5 rise"); step(2, 0, 0, "R5 rise"); step(3, 0, 0, "R5 rise");
    step(2, 1, 1, "R5 top turn"); step(1, 0, 1, "R5 fall");
    step(2, 1, 0, "R5 bottom turn"); step(3, 0, 0, "R10 rise");
    step(2, 1, 1, "R5 top turn");

    // R8 reload at update only
    wr(2'd0, 16'h0008);
    wr(2'd1, 16'd0);
    wr(2'd3, 16'd2);
    rd(2'd3, 16'd2, "R2 arr reads buffer");
    wr(2'd0, 16'h0009);
    step(1, 0, 0, "R8 old limit"); step(2, 0, 0, "R8 old limit");
    step(3, 0, 0, "R8 old limit"); step(4, 0, 0, "R8 old limit");
    step(0, 1, 0, "R8 wrap at old"); step(1, 0, 0, "R8 new limit");
    step(2, 0, 0, "R8 new limit"); step(0, 1, 0, "R8 wrap at new");

    // R9 counter write while running, then R7 disable
    wr(2'd0, 16'h0000);
    wr(2'd3, 16'd10);
    wr(2'd1, 16'd0);
    wr(2'd0, 16'h0001);
    step(1, 0, 0, "R9 run"); step(2, 0, 0, "R9 run");
    wr_en = 1'b1; addr = 2'd1; wdata = 16'd7;
    step(7, 0, 0, "R9 write wins");
    wr_en = 1'b0;
    step(8, 0, 0, "R9 resume"); step(9, 0, 0, "R9 resume");
    step(10, 0, 0, "R9 resume"); step(0, 1, 0, "R9 wrap");
    wr_en = 1'b1; addr = 2'd0; wdata = 16'h0000;
    step(1, 0, 0, "R7 last tick");
    wr_en = 1'b0;
    for (int i = 0; i < 4; i++) step(1, 0, 0, "R7 hold");
    rd(2'd1, 16'd1, "R2 cnt readback");

    // R6 divider preload, applies at next update
    wr(2'd3, 16'd2);
    wr(2'd1, 16'd0);
    wr(2'd2, 16'd1);
    rd(2'd2, 16'd1, "R2 psc readback");
    wr(2'd0, 16'h0001);
    step(1, 0, 0, "R6 old ratio"); step(2, 0, 0, "R6 old ratio");
    step(0, 1, 0, "R6 update"); step(0, 0, 0, "R6 div2");
    step(1, 0, 0, "R6 div2"); step(1, 0, 0, "R6 div2");
    step(2, 0, 0, "R6 div2"); step(2, 0, 0, "R6 div2");
    step(0, 1, 0, "R6 div2 wrap"); step(0, 0, 0, "R6 div2");
    step(1, 0, 0, "R6 div2");

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule